// File: doc/BRIEF.md
# Four-Input Look-Up Logic Cell Column

This block is a column of identical logic cells. Each cell evaluates any Boolean function of four inputs from a 16-bit truth table. It can also merge its result with the cell above it through a cascade link, which is a configurable AND or OR. In a separate arithmetic mode, the same truth table splits into two three-input halves: one half produces a sum bit and the other produces a carry bit for the next cell. A chain of cells therefore forms a ripple adder or counter without using any general routing.

Every cell has one flip-flop. The flip-flop normally registers the cell's combinational result. In packed mode it instead captures a separate data bit, so the look-up table and the register serve unrelated signals. The column shares these control lines:
- two clocks, selected per cell;
- two asynchronous clear/preset lines, selected per cell, with the action chosen per cell;
- a clock enable;
- a synchronous clear and a synchronous load, which counters use;
- a chip-wide reset that overrides everything else.

Per-cell configuration arrives on static configuration ports. Feedback between cells, such as a counter's own bits, is wired outside the block.

Top module: `lut_column`

## Requirements
- R1: With arithmetic mode off and cascade off, `comb_out[i]` equals `cfg_tt[16i + idx]`. Here idx = `data_in[4i+3:4i]`, and `data_in[4i]` is the least significant index bit.
- R2: With `cfg_arith[i]`=1, let k = {carry into cell i, `data_in[4i+1]`, `data_in[4i]`}. The sum is truth-table bit k and the carry out is bit 8+k. In normal mode the cell's carry out is 0. The carry into cell 0 is `carry_in`, the carry into cell i>0 is cell i-1's carry out, and `carry_out` is the carry out of the last cell.
- R3: With `cfg_casc_en[i]`=1, `comb_out[i]` is the look-up result combined with the cascade input: AND when `cfg_casc_or[i]`=0, OR when it is 1. The cascade input of cell 0 is `cascade_in`, the cascade input of cell i>0 is `comb_out[i-1]`, and `cascade_out` equals the last cell's `comb_out`.
- R4: The register updates on the rising edge of `clk_a` when `cfg_clk_sel[i]`=0, or of `clk_b` when it is 1. It updates only while `ce`=1 and holds otherwise. When unpacked, it captures `comb_out[i]`.
- R5: With `cfg_pack[i]`=1, the register captures `pack_d[i]`, while `comb_out[i]` still shows the look-up result.
- R6: With `cfg_sync_en[i]`=1 and `ce`=1:
  - `sclear` loads 0;
  - otherwise `sload` loads `data_in[4i+2]`;
  - `sclear` wins when both are high.
  
  With `cfg_sync_en[i]`=0, both controls are ignored.
- R7: With `cfg_cp_en[i]`=1, the selected line forces the register at once, without a clock. `cfg_cp_sel[i]`=0 selects `cp_a` and 1 selects `cp_b`. The register is forced to 1 when `cfg_cp_preset[i]`=1 and to 0 otherwise. The unselected line has no effect.
- R8: `rst_chip` clears every register at once, overriding preset, clock enable and synchronous controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First block clock |
| clk_b | input | 1 | Second block clock |
| rst_chip | input | 1 | Chip-wide asynchronous clear, active high |
| cp_a | input | 1 | First asynchronous clear/preset line, active high |
| cp_b | input | 1 | Second asynchronous clear/preset line, active high |
| ce | input | 1 | Register clock enable |
| sload | input | 1 | Synchronous load |
| sclear | input | 1 | Synchronous clear |
| carry_in | input | 1 | Carry into cell 0 |
| cascade_in | input | 1 | Cascade input of cell 0 |
| data_in | input | NUM_ELEM*4 | Four data inputs per cell |
| pack_d | input | NUM_ELEM | Packed register data per cell |
| cfg_tt | input | NUM_ELEM*16 | Truth table per cell |
| cfg_arith | input | NUM_ELEM | Arithmetic mode per cell |
| cfg_casc_en | input | NUM_ELEM | Cascade enable per cell |
| cfg_casc_or | input | NUM_ELEM | Cascade operator, 1 = OR |
| cfg_pack | input | NUM_ELEM | Register packing per cell |
| cfg_clk_sel | input | NUM_ELEM | Clock select, 1 = clk_b |
| cfg_cp_sel | input | NUM_ELEM | Clear/preset line select, 1 = cp_b |
| cfg_cp_preset | input | NUM_ELEM | Clear/preset action, 1 = preset |
| cfg_cp_en | input | NUM_ELEM | Clear/preset enable per cell |
| cfg_sync_en | input | NUM_ELEM | Synchronous load/clear enable per cell |
| comb_out | output | NUM_ELEM | Combinational result per cell |
| reg_out | output | NUM_ELEM | Register output per cell |
| carry_out | output | 1 | Carry out of last cell |
| cascade_out | output | 1 | Cascade output of last cell |

## Verification
The synchronous clear and the synchronous load can both be raised for the same clock edge. The bench provokes this on an eight-cell counter: it first loads a non-zero value, then asserts both controls together with a new load pattern. The result is judged correct only if every bit reads zero after that edge. A second collision also gets a check: an asynchronous preset held across an active clock edge, with a zero waiting at the packed data input, must keep the register at one until the preset is released.

// File: rtl/lc_pkg.sv
package lc_pkg;
   localparam int LUT_K = 4;
   localparam int TT_W  = 1 << LUT_K;
   localparam int AR_K  = LUT_K - 1;

   typedef struct packed {
      logic [TT_W-1:0] tt;
      logic            arith;
      logic            casc_en;
      logic            casc_or;
      logic            pack;
      logic            clk_sel;
      logic            cp_sel;
      logic            cp_preset;
      logic            cp_en;
      logic            sync_en;
   } lc_cfg_t;
endpackage

// File: rtl/lc_lut.sv
module lc_lut
   import lc_pkg::*;
(
   input  logic [TT_W-1:0]  tt,
   input  logic [LUT_K-1:0] din,
   input  logic             arith,
   input  logic             cin,
   output logic             lut_o,
   output logic             cout
);
   logic [AR_K-1:0] ar_idx;

   always_comb begin
      ar_idx = {cin, din[AR_K-2:0]};
      if (arith) begin
         lut_o = tt[{1'b0, ar_idx}];
         cout  = tt[{1'b1, ar_idx}];
      end else begin
         lut_o = tt[din];
         cout  = 1'b0;
      end
   end
endmodule

// File: rtl/lc_reg.sv
module lc_reg (
   input  logic clk,
   input  logic arst_clr,
   input  logic arst_pre,
   input  logic ce,
   input  logic sync_en,
   input  logic sclear,
   input  logic sload,
   input  logic load_d,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or posedge arst_clr or posedge arst_pre) begin
      if (arst_clr)
         q <= 1'b0;
      else if (arst_pre)
         q <= 1'b1;
      else if (ce) begin
         if (sync_en && sclear)
            q <= 1'b0;
         else if (sync_en && sload)
            q <= load_d;
         else
            q <= d;
      end
   end

   // R6
   sclr_wins_chk: assert property (@(posedge clk) disable iff (arst_clr || arst_pre)
      (ce && sync_en && sclear) |=> (q == 1'b0));

   // R6
   sload_chk: assert property (@(posedge clk) disable iff (arst_clr || arst_pre)
      (ce && sync_en && !sclear && sload) |=> (q == $past(load_d)));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (arst_clr || arst_pre)
      (!ce) |=> $stable(q));

   // R5
   capture_chk: assert property (@(posedge clk) disable iff (arst_clr || arst_pre)
      (ce && !(sync_en && (sclear || sload))) |=> (q == $past(d)));

   // R8
   async_clr_chk: assert property (@(posedge clk) arst_clr |-> (q == 1'b0));

   // R7
   async_pre_chk: assert property (@(posedge clk) (arst_pre && !arst_clr) |-> (q == 1'b1));
endmodule

// File: rtl/lc_element.sv
module lc_element
   import lc_pkg::*;
(
   input  lc_cfg_t          cfg,
   input  logic [LUT_K-1:0] din,
   input  logic             pack_d,
   input  logic             carry_i,
   input  logic             casc_i,
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             rst_chip,
   input  logic             cp_a,
   input  logic             cp_b,
   input  logic             ce,
   input  logic             sclear,
   input  logic             sload,
   output logic             comb_o,
   output logic             q_o,
   output logic             carry_o
);
   logic lut_v;
   logic reg_clk;
   logic cp_line;
   logic cp_hit;
   logic arst_clr;
   logic arst_pre;
   logic reg_d;

   lc_lut u_lut (
      .tt    (cfg.tt),
      .din   (din),
      .arith (cfg.arith),
      .cin   (carry_i),
      .lut_o (lut_v),
      .cout  (carry_o)
   );

   always_comb begin
      if (!cfg.casc_en)
         comb_o = lut_v;
      else if (cfg.casc_or)
         comb_o = lut_v | casc_i;
      else
         comb_o = lut_v & casc_i;
   end

   assign reg_clk  = cfg.clk_sel ? clk_b : clk_a;
   assign cp_line  = cfg.cp_sel ? cp_b : cp_a;
   assign cp_hit   = cfg.cp_en & cp_line;
   assign arst_clr = rst_chip | (cp_hit & ~cfg.cp_preset);
   assign arst_pre = cp_hit & cfg.cp_preset & ~rst_chip;
   assign reg_d    = cfg.pack ? pack_d : comb_o;

   lc_reg u_reg (
      .clk      (reg_clk),
      .arst_clr (arst_clr),
      .arst_pre (arst_pre),
      .ce       (ce),
      .sync_en  (cfg.sync_en),
      .sclear   (sclear),
      .sload    (sload),
      .load_d   (din[2]),
      .d        (reg_d),
      .q        (q_o)
   );

   // R3
   always_comb begin
      if (cfg.casc_en && !cfg.casc_or && !casc_i)
         cascade_and_chk: assert (comb_o == 1'b0);
   end

   // R3
   always_comb begin
      if (cfg.casc_en && cfg.casc_or && casc_i)
         cascade_or_chk: assert (comb_o == 1'b1);
   end
endmodule

// File: rtl/lut_column.sv
module lut_column
   import lc_pkg::*;
#(
   parameter int NUM_ELEM = 8
) (
   input  logic                     clk_a,
   input  logic                     clk_b,
   input  logic                     rst_chip,
   input  logic                     cp_a,
   input  logic                     cp_b,
   input  logic                     ce,
   input  logic                     sload,
   input  logic                     sclear,
   input  logic                     carry_in,
   input  logic                     cascade_in,
   input  logic [NUM_ELEM*4-1:0]    data_in,
   input  logic [NUM_ELEM-1:0]      pack_d,
   input  logic [NUM_ELEM*16-1:0]   cfg_tt,
   input  logic [NUM_ELEM-1:0]      cfg_arith,
   input  logic [NUM_ELEM-1:0]      cfg_casc_en,
   input  logic [NUM_ELEM-1:0]      cfg_casc_or,
   input  logic [NUM_ELEM-1:0]      cfg_pack,
   input  logic [NUM_ELEM-1:0]      cfg_clk_sel,
   input  logic [NUM_ELEM-1:0]      cfg_cp_sel,
   input  logic [NUM_ELEM-1:0]      cfg_cp_preset,
   input  logic [NUM_ELEM-1:0]      cfg_cp_en,
   input  logic [NUM_ELEM-1:0]      cfg_sync_en,
   output logic [NUM_ELEM-1:0]      comb_out,
   output logic [NUM_ELEM-1:0]      reg_out,
   output logic                     carry_out,
   output logic                     cascade_out
);
   localparam int LAST = NUM_ELEM - 1;

   if (NUM_ELEM < 1) begin : g_bad_count
      $error("lut_column needs at least one cell");
   end
   if (TT_W != 16) begin : g_bad_width
      $error("truth table width must match the cfg_tt slice of 16 bits");
   end

   logic [NUM_ELEM:0] carry_w;
   logic [NUM_ELEM:0] casc_w;

   assign carry_w[0] = carry_in;
   assign casc_w[0]  = cascade_in;

   for (genvar i = 0; i < NUM_ELEM; i++) begin : g_cell
      lc_cfg_t cfg;

      assign cfg.tt        = cfg_tt[i*TT_W +: TT_W];
      assign cfg.arith     = cfg_arith[i];
      assign cfg.casc_en   = cfg_casc_en[i];
      assign cfg.casc_or   = cfg_casc_or[i];
      assign cfg.pack      = cfg_pack[i];
      assign cfg.clk_sel   = cfg_clk_sel[i];
      assign cfg.cp_sel    = cfg_cp_sel[i];
      assign cfg.cp_preset = cfg_cp_preset[i];
      assign cfg.cp_en     = cfg_cp_en[i];
      assign cfg.sync_en   = cfg_sync_en[i];

      lc_element u_cell (
         .cfg      (cfg),
         .din      (data_in[i*LUT_K +: LUT_K]),
         .pack_d   (pack_d[i]),
         .carry_i  (carry_w[i]),
         .casc_i   (casc_w[i]),
         .clk_a    (clk_a),
         .clk_b    (clk_b),
         .rst_chip (rst_chip),
         .cp_a     (cp_a),
         .cp_b     (cp_b),
         .ce       (ce),
         .sclear   (sclear),
         .sload    (sload),
         .comb_o   (comb_out[i]),
         .q_o      (reg_out[i]),
         .carry_o  (carry_w[i+1])
      );

      assign casc_w[i+1] = comb_out[i];
   end

   assign carry_out   = carry_w[NUM_ELEM];
   assign cascade_out = comb_out[LAST];
endmodule

// File: tb/tb_lut_column.sv
module tb_lut_column;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam int NV = 13;
   // {tt[15:0], d[3:0], carry_in, cascade_in, arith, casc_en, casc_or}
   localparam logic [24:0] VECS [NV] = '{
      {16'h6996, 4'hB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {16'h6996, 4'hC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {16'h8000, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {16'h8000, 4'hE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {16'hFFFE, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {16'hA05A, 4'h1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {16'hA05A, 4'h1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      {16'hE896, 4'h3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {16'h1234, 4'h5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      {16'hFFFF, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      {16'h0000, 4'h9, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
      {16'h0000, 4'h9, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
      {16'hA05A, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
   };

   logic clk_a = 1'b0;
   logic clk_b = 1'b0;
   logic rst_chip, cp_a, cp_b, ce, sload, sclear, carry_in, cascade_in;
   logic [N*4-1:0]  data_in, data_drv;
   logic [N-1:0]    pack_d, load_val;
   logic            fb_mode;
   logic [N*16-1:0] cfg_tt;
   logic [N-1:0]    cfg_arith, cfg_casc_en, cfg_casc_or, cfg_pack, cfg_clk_sel;
   logic [N-1:0]    cfg_cp_sel, cfg_cp_preset, cfg_cp_en, cfg_sync_en;
   logic [N-1:0]    comb_out, reg_out;
   logic            carry_out, cascade_out;
   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk_a = ~clk_a;
   initial begin
      #2;
      forever #(CLK_PERIOD) clk_b = ~clk_b;
   end

   always_comb begin
      if (fb_mode) begin
         for (int i = 0; i < N; i++)
            data_in[i*4 +: 4] = {1'b0, load_val[i], 1'b0, reg_out[i]};
      end else
         data_in = data_drv;
   end

   lut_column #(.NUM_ELEM(N)) dut (
      .clk_a(clk_a), .clk_b(clk_b), .rst_chip(rst_chip), .cp_a(cp_a), .cp_b(cp_b),
      .ce(ce), .sload(sload), .sclear(sclear), .carry_in(carry_in),
      .cascade_in(cascade_in), .data_in(data_in), .pack_d(pack_d), .cfg_tt(cfg_tt),
      .cfg_arith(cfg_arith), .cfg_casc_en(cfg_casc_en), .cfg_casc_or(cfg_casc_or),
      .cfg_pack(cfg_pack), .cfg_clk_sel(cfg_clk_sel), .cfg_cp_sel(cfg_cp_sel),
      .cfg_cp_preset(cfg_cp_preset), .cfg_cp_en(cfg_cp_en), .cfg_sync_en(cfg_sync_en),
      .comb_out(comb_out), .reg_out(reg_out), .carry_out(carry_out),
      .cascade_out(cascade_out)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [1:0] lut_model(input logic [24:0] v);
      logic [15:0] t;
      logic [2:0]  ai;
      logic        s, c;
      t  = v[24:9];
      ai = {v[4], v[6], v[5]};
      if (v[2]) begin
         s = t[{1'b0, ai}];
         c = t[{1'b1, ai}];
      end else begin
         s = t[v[8:5]];
         c = 1'b0;
      end
      if (v[1])
         s = v[0] ? (s | v[3]) : (s & v[3]);
      return {c, s};
   endfunction

   task automatic edge_a();
      @(posedge clk_a);
      #2;
   endtask

   task automatic safe_point();
      @(negedge clk_b);
      @(negedge clk_a);
   endtask

   initial begin
      repeat (50000) @(posedge clk_a);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] cnt;
      logic [1:0] m;
      rst_chip = 1'b1;
      cp_a = 0; cp_b = 0; ce = 1; sload = 0; sclear = 0;
      carry_in = 0; cascade_in = 0; data_drv = '0; pack_d = '0; load_val = '0;
      fb_mode = 0; cfg_tt = '0; cfg_arith = '0; cfg_casc_en = '0; cfg_casc_or = '0;
      cfg_pack = '0; cfg_clk_sel = '0; cfg_cp_sel = '0; cfg_cp_preset = '0;
      cfg_cp_en = '0; cfg_sync_en = '0;
      repeat (3) edge_a();
      chk("R8", "registers under chip reset", reg_out, 0);
      @(negedge clk_a);
      rst_chip = 1'b0;

      // R1 R2 R3 vector table on cells 0 and 1; cell 1 exposes cell 0's carry
      cfg_tt[31:16] = 16'h00F0;
      cfg_arith[1]  = 1'b1;
      for (int k = 0; k < NV; k++) begin
         @(negedge clk_a);
         cfg_tt[15:0]   = VECS[k][24:9];
         data_drv[3:0]  = VECS[k][8:5];
         carry_in       = VECS[k][4];
         cascade_in     = VECS[k][3];
         cfg_arith[0]   = VECS[k][2];
         cfg_casc_en[0] = VECS[k][1];
         cfg_casc_or[0] = VECS[k][0];
         #1;
         m = lut_model(VECS[k]);
         chk(VECS[k][1] ? "R3" : (VECS[k][2] ? "R2" : "R1"), "cell0 result",
             comb_out[0], m[0]);
         chk("R2", "carry from cell0", comb_out[1], m[1]);
      end
      chk("R2", "normal cells give no carry", carry_out, 0);

      // R2 R6 counter built on the carry chain
      @(negedge clk_a);
      cfg_tt = {N{16'hA05A}};
      cfg_arith = '1; cfg_casc_en = '0; cfg_sync_en = '1;
      carry_in = 1; fb_mode = 1; load_val = 8'hFD; sload = 1;
      edge_a();
      chk("R6", "counter load", reg_out, 8'hFD);
      cnt = 8'hFD;
      @(negedge clk_a);
      sload = 0;
      for (int c = 0; c < 4; c++) begin
         edge_a();
         cnt = cnt + 8'd1;
         chk("R2", "counter value", reg_out, cnt);
         chk("R2", "counter carry out", carry_out, (cnt == 8'hFF));
      end
      @(negedge clk_a);
      load_val = 8'h55; sload = 1; sclear = 1;
      edge_a();
      chk("R6", "clear beats load", reg_out, 0);
      @(negedge clk_a);
      sclear = 0;
      edge_a();
      chk("R6", "reload", reg_out, 8'h55);
      @(negedge clk_a);
      sload = 0; ce = 0;
      repeat (2) edge_a();
      chk("R4", "enable low holds", reg_out, 8'h55);
      @(negedge clk_a);
      ce = 1; cfg_sync_en = '0; sclear = 1; sload = 1;
      edge_a();
      chk("R6", "sync controls ignored when disabled", reg_out, 8'h56);
      @(negedge clk_a);
      sclear = 0; sload = 0; fb_mode = 0; carry_in = 0;

      // R3 sixteen-input AND and OR on cells 4..7
      cfg_arith = '0;
      cfg_tt[127:64] = {4{16'h8000}};
      cfg_casc_en = 8'hE0; cfg_casc_or = '0;
      data_drv = 32'hFFFF_0000;
      #1 chk("R3", "and16 all ones", cascade_out, 1);
      @(negedge clk_a);
      data_drv = 32'hFFFE_0000;
      #1 chk("R3", "and16 low bit zero", cascade_out, 0);
      @(negedge clk_a);
      data_drv = 32'h7FFF_0000;
      #1 chk("R3", "and16 top bit zero", cascade_out, 0);
      @(negedge clk_a);
      data_drv = 32'hFF7F_0000;
      #1 chk("R3", "and16 middle zero", cascade_out, 0);
      @(negedge clk_a);
      cfg_tt[127:64] = {4{16'hFFFE}};
      cfg_casc_or = 8'hE0; data_drv = 32'h0000_0000;
      #1 chk("R3", "or16 all zero", cascade_out, 0);
      @(negedge clk_a);
      data_drv = 32'h0100_0000;
      #1 chk("R3", "or16 one bit", cascade_out, 1);

      // R5 register packing on cell 0
      @(negedge clk_a);
      cfg_casc_en = '0; cfg_casc_or = '0; cfg_tt[15:0] = 16'h6996;
      cfg_pack[0] = 1; data_drv = 32'h7; pack_d[0] = 0;
      edge_a();
      chk("R5", "packed reg takes pack_d", reg_out[0], 0);
      chk("R5", "lut output independent", comb_out[0], 1);
      @(negedge clk_a);
      data_drv = 32'h3; pack_d[0] = 1;
      edge_a();
      chk("R5", "packed reg takes pack_d", reg_out[0], 1);
      chk("R5", "lut output independent", comb_out[0], 0);

      // R4 second clock select
      safe_point();
      cfg_clk_sel[0] = 1; pack_d[0] = 0;
      @(posedge clk_b);
      #1 chk("R4", "capture on clk_b", reg_out[0], 0);
      pack_d[0] = 1;
      edge_a();
      chk("R4", "clk_a edge ignored", reg_out[0], 0);
      @(posedge clk_b);
      #1 chk("R4", "capture on clk_b", reg_out[0], 1);
      safe_point();
      cfg_clk_sel[0] = 0; pack_d[0] = 0;
      edge_a();
      chk("R4", "back on clk_a", reg_out[0], 0);

      // R7 asynchronous preset and clear
      @(negedge clk_a);
      cfg_cp_en[0] = 1; cfg_cp_sel[0] = 1; cfg_cp_preset[0] = 1; cp_a = 1;
      #1 chk("R7", "unselected line ignored", reg_out[0], 0);
      edge_a();
      chk("R7", "unselected line ignored across edge", reg_out[0], 0);
      @(negedge clk_a);
      cp_a = 0; cp_b = 1;
      #1 chk("R7", "preset without clock", reg_out[0], 1);
      edge_a();
      chk("R7", "preset beats clocked zero", reg_out[0], 1);
      @(negedge clk_a);
      cp_b = 0;
      edge_a();
      chk("R7", "clocked after release", reg_out[0], 0);
      @(negedge clk_a);
      cfg_cp_preset[0] = 0; pack_d[0] = 1;
      edge_a();
      chk("R7", "setup for clear", reg_out[0], 1);
      @(negedge clk_a);
      cp_b = 1;
      #1 chk("R7", "clear without clock", reg_out[0], 0);
      @(negedge clk_a);
      cp_b = 0;
      edge_a();

      // R8 chip reset overrides preset
      @(negedge clk_a);
      cfg_cp_preset[0] = 1; cp_b = 1; cfg_pack = '1; pack_d = '1;
      #1 chk("R7", "preset again", reg_out[0], 1);
      @(negedge clk_a);
      rst_chip = 1;
      #1 chk("R8", "chip reset clears all", reg_out, 0);
      edge_a();
      chk("R8", "chip reset holds across edge", reg_out, 0);
      @(negedge clk_a);
      cp_b = 0; rst_chip = 0;
      edge_a();
      chk("R8", "normal capture after reset", reg_out, 8'hFF);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule